// File: doc/BRIEF.md
# Far Call Stack Sequencer

This block performs the register and stack side effects of a subroutine call once decode has settled on one. It owns the code selector, the instruction pointer and the stack pointer. It accepts one call request at a time. A near call stays inside the current code segment and writes one word to the stack: the return address. A far call names a new selector and offset. It writes the old code selector as a zero-extended 32-bit word, then the return address. After that it asks the descriptor-table lookup to validate the new selector. The selector and instruction pointer change only when that lookup reports success.

The stack grows downward. Each push first moves the stack pointer down by one word and then writes at the new stack pointer. Every push carries the stack segment selector on the write port. If the descriptor lookup reports a fault, nothing of the call remains visible: the stack pointer returns to its value before the call, the selector and instruction pointer keep their old values, and a fault pulse replaces the completion pulse.

Top module: `fcall_seq`

## Requirements
- R1: After reset, `cs_out` equals `CS_RST` (default 0x0008), `ip_out` equals `IP_RST` (default 0), and `sp_out` equals `SP_RST` (default 0x0009_0000). `busy`, `done`, `fault`, `mem_wr_en` and `dl_req` are all low.
- R2: A near call (`req_far`=0) accepted at a clock edge makes exactly one write in the following cycle. That write goes to address `sp_out`-4, carries the return address as data and has `mem_wr_seg` = `ss`. At the next edge `sp_out` drops by 4, `ip_out` takes the target offset, `cs_out` is unchanged and `done` rises.
- R3: The first write of a far call, in the cycle after acceptance, goes to `sp_out`-4 and carries the old code selector zero-extended to 32 bits (0x000C becomes 0x0000000C).
- R4: The second write of a far call, one cycle later, goes to the original stack pointer minus 8 and carries the return address. After it, `sp_out` is the original value minus 8.
- R5: After both pushes, `dl_req` is high with `dl_sel` equal to the target selector. It stays high, with no write and with `cs_out`/`ip_out` unchanged, until `dl_done` is sampled high.
- R6: When `dl_done` is sampled high with `dl_fault` low, the next cycle shows `cs_out` = target selector, `ip_out` = target offset and `done` high.
- R7: When `dl_done` is sampled high with `dl_fault` high, the next cycle shows `fault` high, `done` low, `sp_out` back at its value before the call, and `cs_out`/`ip_out` unchanged.
- R8: A request raised while `busy` is high, including one in the same cycle as `dl_done`, is ignored. It causes no write and changes no register.
- R9: `done` and `fault` are one-cycle pulses and are never high together. `busy` is low in the cycle in which either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Call request strobe |
| req_far | input | 1 | 1 = far call, 0 = near call |
| req_ret | input | ADDR_W | Return address to push |
| req_sel | input | SEL_W | Target code selector (far only) |
| req_off | input | ADDR_W | Target offset |
| ss | input | SEL_W | Stack segment selector |
| mem_wr_en | output | 1 | Stack write strobe |
| mem_wr_seg | output | SEL_W | Segment of the stack write |
| mem_wr_addr | output | ADDR_W | Offset of the stack write |
| mem_wr_data | output | ADDR_W | Word written |
| dl_req | output | 1 | Descriptor load request, held until answered |
| dl_sel | output | SEL_W | Selector to look up |
| dl_done | input | 1 | Descriptor lookup finished |
| dl_fault | input | 1 | Lookup failed (valid with `dl_done`) |
| cs_out | output | SEL_W | Current code selector |
| ip_out | output | ADDR_W | Current instruction pointer |
| sp_out | output | ADDR_W | Current stack pointer |
| busy | output | 1 | A call is in progress |
| done | output | 1 | Call completed pulse |
| fault | output | 1 | Call aborted pulse |

## Verification
Two events can arrive in the same cycle: the descriptor lookup finishing and a fresh call request. The sequencer is still busy when the lookup finishes, so the request must be dropped even though `busy` falls one edge later. The bench raises `req_valid` together with `dl_done`. It then judges that no stack write follows, that the stack pointer stays where the completed far call left it, and that `cs_out` holds the new selector. The same check is repeated for a request raised in the middle of the lookup wait.

// File: rtl/fcall_pkg.sv
package fcall_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH_SEL,
    ST_PUSH_RET,
    ST_DESC_WAIT
  } call_st_e;
endpackage

// File: rtl/fcall_ctrl.sv
module fcall_ctrl
  import fcall_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     req_far,
  input  logic     dl_done,
  input  logic     dl_fault,
  output call_st_e st,
  output logic     accept,
  output logic     push_sel,
  output logic     push_ret,
  output logic     desc_wait,
  output logic     finish_ok,
  output logic     finish_bad
);
  call_st_e st_nx;
  logic     far_q;

  assign accept     = (st == ST_IDLE) && req_valid;
  assign push_sel   = (st == ST_PUSH_SEL);
  assign push_ret   = (st == ST_PUSH_RET);
  assign desc_wait  = (st == ST_DESC_WAIT);
  assign finish_ok  = (push_ret && !far_q) || (desc_wait && dl_done && !dl_fault);
  assign finish_bad = desc_wait && dl_done && dl_fault;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:      if (req_valid) st_nx = req_far ? ST_PUSH_SEL : ST_PUSH_RET;
      ST_PUSH_SEL:  st_nx = ST_PUSH_RET;
      ST_PUSH_RET:  st_nx = far_q ? ST_DESC_WAIT : ST_IDLE;
      ST_DESC_WAIT: if (dl_done) st_nx = ST_IDLE;
      default:      st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      far_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) far_q <= req_far;
    end
  end
endmodule

// File: rtl/fcall_regs.sv
module fcall_regs #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter logic [SEL_W-1:0]  CS_RST = 16'h0008,
  parameter logic [ADDR_W-1:0] IP_RST = 32'h0,
  parameter logic [ADDR_W-1:0] SP_RST = 32'h0009_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_ret,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_off,
  input  logic              push_sel,
  input  logic              push_ret,
  input  logic              desc_wait,
  input  logic              finish_ok,
  input  logic              finish_bad,
  output logic [SEL_W-1:0]  cs_q,
  output logic [ADDR_W-1:0] ip_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic [SEL_W-1:0]  lat_sel,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] wr_data
);
  localparam int WORD_BYTES = ADDR_W / 8;
  localparam int PAD_W      = ADDR_W - SEL_W;

  logic [ADDR_W-1:0] lat_ret, lat_off, sp_save;

  function automatic logic [ADDR_W-1:0] step_down(input logic [ADDR_W-1:0] p);
    return p - ADDR_W'(WORD_BYTES);
  endfunction

  function automatic logic [ADDR_W-1:0] widen_sel(input logic [SEL_W-1:0] s);
    return {{PAD_W{1'b0}}, s};
  endfunction

  assign wr_addr = step_down(sp_q);
  assign wr_data = push_sel ? widen_sel(cs_q) : lat_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= CS_RST;
      ip_q    <= IP_RST;
      sp_q    <= SP_RST;
      sp_save <= SP_RST;
      lat_sel <= '0;
      lat_ret <= '0;
      lat_off <= '0;
    end else begin
      if (accept) begin
        lat_ret <= req_ret;
        lat_sel <= req_sel;
        lat_off <= req_off;
        sp_save <= sp_q;
      end
      if (push_sel || push_ret) sp_q <= wr_addr;
      if (finish_ok) begin
        ip_q <= lat_off;
        if (desc_wait) cs_q <= lat_sel;
      end
      if (finish_bad) sp_q <= sp_save;
    end
  end
endmodule

// File: rtl/fcall_seq.sv
module fcall_seq #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter logic [SEL_W-1:0]  CS_RST = 16'h0008,
  parameter logic [ADDR_W-1:0] IP_RST = 32'h0,
  parameter logic [ADDR_W-1:0] SP_RST = 32'h0009_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_far,
  input  logic [ADDR_W-1:0] req_ret,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [SEL_W-1:0]  ss,
  output logic              mem_wr_en,
  output logic [SEL_W-1:0]  mem_wr_seg,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [ADDR_W-1:0] mem_wr_data,
  output logic              dl_req,
  output logic [SEL_W-1:0]  dl_sel,
  input  logic              dl_done,
  input  logic              dl_fault,
  output logic [SEL_W-1:0]  cs_out,
  output logic [ADDR_W-1:0] ip_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic              busy,
  output logic              done,
  output logic              fault
);
  import fcall_pkg::*;

  call_st_e st;
  logic accept, push_sel, push_ret, desc_wait, finish_ok, finish_bad;
  logic done_q, fault_q;

  fcall_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_far(req_far),
    .dl_done(dl_done), .dl_fault(dl_fault), .st(st), .accept(accept),
    .push_sel(push_sel), .push_ret(push_ret), .desc_wait(desc_wait),
    .finish_ok(finish_ok), .finish_bad(finish_bad)
  );

  fcall_regs #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .CS_RST(CS_RST), .IP_RST(IP_RST), .SP_RST(SP_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_ret(req_ret), .req_sel(req_sel),
    .req_off(req_off), .push_sel(push_sel), .push_ret(push_ret), .desc_wait(desc_wait),
    .finish_ok(finish_ok), .finish_bad(finish_bad), .cs_q(cs_out), .ip_q(ip_out),
    .sp_q(sp_out), .lat_sel(dl_sel), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= finish_ok;
      fault_q <= finish_bad;
    end
  end

  assign mem_wr_en  = push_sel || push_ret;
  assign mem_wr_seg = ss;
  assign dl_req     = desc_wait;
  assign busy       = (st != ST_IDLE);
  assign done       = done_q;
  assign fault      = fault_q;
endmodule

// File: rtl/fcall_seq_chk.sv
module fcall_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [ADDR_W-1:0] mem_wr_data,
  input logic              dl_req,
  input logic [SEL_W-1:0]  dl_sel,
  input logic              dl_done,
  input logic              dl_fault,
  input logic [SEL_W-1:0]  cs_out,
  input logic [ADDR_W-1:0] ip_out,
  input logic [ADDR_W-1:0] sp_out,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              push_sel
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_wr_en && !dl_req));

  assert_push_moves_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (sp_out == $past(mem_wr_addr)));

  assert_sel_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_sel |-> (mem_wr_data[ADDR_W-1:SEL_W] == '0 && mem_wr_data[SEL_W-1:0] == cs_out));

  assert_wait_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_req && !dl_done) |=> (dl_req && $stable(cs_out) && $stable(ip_out) && $stable(dl_sel)));

  assert_load_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_req && dl_done && !dl_fault) |=> (done && cs_out == $past(dl_sel)));

  assert_fault_unwind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_req && dl_done && dl_fault) |=>
      (fault && !done && sp_out == $past(sp_out) + ADDR_W'(2 * (ADDR_W / 8)) && $stable(cs_out)));

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault) && !((done || fault) && busy));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind fcall_seq fcall_seq_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data), .dl_req(dl_req), .dl_sel(dl_sel), .dl_done(dl_done),
  .dl_fault(dl_fault), .cs_out(cs_out), .ip_out(ip_out), .sp_out(sp_out),
  .busy(busy), .done(done), .fault(fault), .push_sel(push_sel)
);

// File: tb/fcall_seq_bench.sv
module fcall_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_far = 1'b0;
  logic [31:0] req_ret = '0, req_off = '0;
  logic [15:0] req_sel = '0, ss = 16'h0010;
  logic        mem_wr_en, dl_req, busy, done, fault;
  logic [15:0] mem_wr_seg, dl_sel, cs_out;
  logic [31:0] mem_wr_addr, mem_wr_data, ip_out, sp_out;
  logic        dl_done = 1'b0, dl_fault = 1'b0;

  int checks = 0, fails = 0;
  logic [31:0] e_sp = 32'h0009_0000, e_ip = 32'h0;
  logic [15:0] e_cs = 16'h0008;

  always #2.5 clk = ~clk;

  fcall_seq u_fcall_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_far(req_far), .req_ret(req_ret),
    .req_sel(req_sel), .req_off(req_off), .ss(ss), .mem_wr_en(mem_wr_en),
    .mem_wr_seg(mem_wr_seg), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .dl_req(dl_req), .dl_sel(dl_sel), .dl_done(dl_done), .dl_fault(dl_fault),
    .cs_out(cs_out), .ip_out(ip_out), .sp_out(sp_out), .busy(busy), .done(done), .fault(fault)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  task automatic regs_chk(input string tag);
    chk({tag, " sp"}, sp_out, e_sp);
    chk({tag, " ip"}, ip_out, e_ip);
    chk({tag, " cs"}, 32'(cs_out), 32'(e_cs));
  endtask

  // presents a request for one edge; returns in the cycle after acceptance
  task automatic issue(input logic far, input logic [31:0] ret, input logic [15:0] sel,
                       input logic [31:0] off);
    @(negedge clk);
    req_valid = 1'b1; req_far = far; req_ret = ret; req_sel = sel; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset_R1();
    regs_chk("R1 reset");
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done/fault", {30'b0, done, fault}, 0);
    chk("R1 wr_en/dl_req", {30'b0, mem_wr_en, dl_req}, 0);
  endtask

  task automatic t_near_R2(input logic [31:0] ret, input logic [31:0] off);
    issue(1'b0, ret, 16'h7777, off);
    chk("R2 wr_en", 32'(mem_wr_en), 1);
    chk("R2 addr", mem_wr_addr, e_sp - 4);
    chk("R2 data", mem_wr_data, ret);
    chk("R2 seg", 32'(mem_wr_seg), 32'(ss));
    @(negedge clk);
    e_sp = e_sp - 4; e_ip = off;
    regs_chk("R2 after");
    chk("R2 done", 32'(done), 1);
    chk("R9 busy low with done", 32'(busy), 0);
    chk("R2 single write", 32'(mem_wr_en), 0);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 0);
  endtask

  task automatic far_pushes(input logic [31:0] ret, input logic [15:0] sel, input logic [31:0] off);
    issue(1'b1, ret, sel, off);
    chk("R3 wr_en", 32'(mem_wr_en), 1);
    chk("R3 addr", mem_wr_addr, e_sp - 4);
    chk("R3 zext cs", mem_wr_data, {16'h0, e_cs});
    @(negedge clk);
    chk("R4 wr_en", 32'(mem_wr_en), 1);
    chk("R4 addr", mem_wr_addr, e_sp - 8);
    chk("R4 data", mem_wr_data, ret);
    @(negedge clk);
    chk("R4 sp", sp_out, e_sp - 8);
    chk("R5 dl_req", 32'(dl_req), 1);
    chk("R5 dl_sel", 32'(dl_sel), 32'(sel));
    chk("R5 no write", 32'(mem_wr_en), 0);
  endtask

  task automatic t_far_ok_R6(input logic [31:0] ret, input logic [15:0] sel, input logic [31:0] off);
    logic [31:0] sp0;
    sp0 = e_sp;
    far_pushes(ret, sel, off);
    e_sp = sp0 - 8;
    regs_chk("R5 wait");
    req_valid = 1'b1; req_far = 1'b0; req_ret = 32'hDEAD_0000;   // R8 mid-wait
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 mid-wait no write", 32'(mem_wr_en), 0);
    chk("R5 still waiting", 32'(dl_req), 1);
    regs_chk("R8 mid-wait regs");
    dl_done = 1'b1; req_valid = 1'b1; req_far = 1'b1;              // R8 same cycle
    @(negedge clk);
    dl_done = 1'b0; req_valid = 1'b0;
    e_cs = sel; e_ip = off;
    regs_chk("R6 commit");
    chk("R6 done", 32'(done), 1);
    chk("R9 no fault", 32'(fault), 0);
    chk("R8 not accepted", 32'(busy), 0);
    @(negedge clk);
    chk("R8 no write after", 32'(mem_wr_en), 0);
    chk("R9 done one cycle", 32'(done), 0);
    regs_chk("R8 regs after");
  endtask

  task automatic t_far_fault_R7(input logic [31:0] ret, input logic [15:0] sel, input logic [31:0] off);
    far_pushes(ret, sel, off);
    dl_done = 1'b1; dl_fault = 1'b1;
    @(negedge clk);
    dl_done = 1'b0; dl_fault = 1'b0;
    regs_chk("R7 unwind");
    chk("R7 fault", 32'(fault), 1);
    chk("R7 no done", 32'(done), 0);
    @(negedge clk);
    chk("R9 fault one cycle", 32'(fault), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_R1();
    t_near_R2(32'h1111_2220, 32'h0000_3000);
    t_far_ok_R6(32'hABCD_1234, 16'h000C, 32'h1212_3434);
    t_far_fault_R7(32'h0000_5550, 16'h0040, 32'h0000_9000);
    t_far_ok_R6(32'h0BAD_F00C, 16'hF00D, 32'h0000_0400);
    t_far_ok_R6(32'h2222_0000, 16'h0008, 32'h0000_0100);   // R3 zext of 0xF00D
    t_near_R2(32'h0000_0104, 32'h0000_0200);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule